// File: doc/BRIEF.md
# Byte-wide indirect access bridge

The bridge is the target side of an indirect access window. A host that can only move single bytes reaches two 32-bit word stores through a sixteen-location byte window. One store is a word-addressed memory and the other is a small register file. The host stages data and address bytes in window locations. A write to one particular location starts the access.

Each access takes a fixed modelled latency of `LAT` clock cycles. During that time the `ready_o` line is low. The host polls it, either on the port or as a bit of the status byte, with a bounded number of polls. When a read finishes, the word is captured into a separate read-back register. The host then fetches the word one byte lane at a time. The usual fetch sequence writes zero to a data location before reading it. That write lands in the staging register only, so it never disturbs the captured word. A launch that arrives while an access is still in flight is dropped, and the bridge records this in a sticky error flag.

Top module: `ibr_bridge`

## Requirements
- R1: In the memory window, offsets 0..3 hold data byte lane k (word bits 8k+7:8k) at offset k. Offset 4 holds word-address bits 23:16, offset 5 holds bits 15:8 and offset 6 holds bits 7:0. Reading offsets 4, 5 and 6 returns the byte last written there.
- R2: A host write to offset 6 starts a memory access. Bit 6 of the byte at offset 4 selects the direction: 1 is a write and 0 is a read. Bits 7:6 of that byte are not address bits. A memory write stores the four staged data bytes as they stand at the launch.
- R3: Memory word addresses use only their low `MEM_AW` bits and register addresses only their low `REG_AW` bits. Any higher address bits are ignored, so such an address aliases onto a lower location.
- R4: In the register window, offsets 8..11 hold data lane k at offset 8+k. Offset 12 holds register-address bits 7:0 and offset 13 holds bits 15:8. A write to offset 14 starts a register access, and bit 0 of the written byte selects the direction: 1 is a write and 0 is a read.
- R5: After reset `ready_o` is 1. In the cycle after an accepted launch, `ready_o` is 0.
- R6: `ready_o` returns to 1 exactly `LAT` clock edges after the edge that accepted the launch.
- R7: Reads of offsets 0..3 (memory) and 8..11 (register) return the word captured by the last completed read of that window. Host writes to those offsets change only the staging bytes. They neither start an access nor alter the captured word.
- R8: A launch that arrives while an access is in flight is ignored and sets `err_o`. The flag stays set until reset.
- R9: Offset 15 returns a status byte: bit 1 is ready, bit 0 is the sticky error flag and the other bits are 0. After reset the captured words are 0 and the status byte reads 0x02.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hb_we | input | 1 | Host byte write strobe |
| hb_off | input | 4 | Window offset for writes and reads |
| hb_wdata | input | 8 | Byte written by the host |
| hb_rdata | output | 8 | Byte at `hb_off`, combinational |
| ready_o | output | 1 | High when no access is in flight |
| err_o | output | 1 | Sticky flag for a launch that arrived while busy |

## Verification
Window reads are combinational, so `hb_rdata` is due in the same cycle as `hb_off`. A staging write takes effect at the next rising edge. `ready_o` falls one edge after the launching write and rises `LAT` edges after that edge. The bench drives and samples only on falling edges. It checks the low level at the first falling edge after the launch and again one falling edge before the expected rise, then checks the high level at the next falling edge. Data and error checks are made only after ready has been polled high, and so after the capture edge.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

    localparam logic [3:0] OFF_MD0    = 4'd0;
    localparam logic [3:0] OFF_MA_HI  = 4'd4;
    localparam logic [3:0] OFF_MA_MID = 4'd5;
    localparam logic [3:0] OFF_MA_LO  = 4'd6;
    localparam logic [3:0] OFF_RD0    = 4'd8;
    localparam logic [3:0] OFF_RA_LO  = 4'd12;
    localparam logic [3:0] OFF_RA_HI  = 4'd13;
    localparam logic [3:0] OFF_RDIR   = 4'd14;
    localparam logic [3:0] OFF_STAT   = 4'd15;

    localparam int MEM_WR_BIT = 22;  // bit 6 of the high address byte

    typedef enum logic { OP_MEM = 1'b0, OP_REG = 1'b1 } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic        is_wr;
        logic [23:0] addr;
        logic [31:0] data;
    } op_t;

    typedef struct packed {
        logic [31:0] mwd;   // memory staging data
        logic [23:0] madr;  // memory address bytes incl. flag bits
        logic [31:0] rwd;   // register staging data
        logic [15:0] radr;  // register address
        logic [7:0]  rdir;  // last direction byte
        logic [31:0] mrd;   // captured memory read word
        logic [31:0] rrd;   // captured register read word
    } win_t;

endpackage

// File: rtl/ibr_word_store.sv
module ibr_word_store #(
    parameter int AW = 10,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/ibr_txn_seq.sv
module ibr_txn_seq
    import ibr_pkg::*;
#(
    parameter int LAT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic launch_i,
    input  op_t  op_i,
    output logic busy_o,
    output logic ready_o,
    output logic err_o,
    output logic fin_o,
    output op_t  op_o
);
    localparam int CW  = (LAT > 1) ? $clog2(LAT) : 1;
    localparam int CKW = $clog2(LAT + 2);

    typedef struct packed {
        logic          busy;
        logic          ready;
        logic          err;
        logic [CW-1:0] cnt;
        op_t           op;
    } seq_t;

    localparam seq_t SEQ_RST = '{busy: 1'b0, ready: 1'b1, err: 1'b0,
                                 cnt: '0, op: '0};

    seq_t seq_d, seq_q;
    logic fin;

    always_comb begin
        seq_d = seq_q;
        fin   = seq_q.busy && (seq_q.cnt == '0);
        if (fin) begin
            seq_d.busy  = 1'b0;
            seq_d.ready = 1'b1;
        end else if (seq_q.busy) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end
        if (launch_i) begin
            if (seq_q.busy) begin
                seq_d.err = 1'b1;
            end else begin
                seq_d.busy  = 1'b1;
                seq_d.ready = 1'b0;
                seq_d.cnt   = CW'(LAT - 1);
                seq_d.op    = op_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= SEQ_RST;
        else        seq_q <= seq_d;
    end

    assign busy_o  = seq_q.busy;
    assign ready_o = seq_q.ready;
    assign err_o   = seq_q.err;
    assign fin_o   = fin;
    assign op_o    = seq_q.op;

    // edges since the last accepted launch, for the latency check
    logic [CKW-1:0] lat_ck_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                          lat_ck_q <= '0;
        else if (launch_i && !seq_q.busy)    lat_ck_q <= '0;
        else if (seq_q.busy)                 lat_ck_q <= lat_ck_q + 1'b1;
    end

    a_r5_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && !seq_q.busy) |=> !ready_o);

    a_r6_ready_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> (lat_ck_q == CKW'(LAT)));

    a_r8_busy_launch_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_i && seq_q.busy) |=> err_o);

    a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

endmodule

// File: rtl/ibr_bridge.sv
module ibr_bridge
    import ibr_pkg::*;
#(
    parameter int MEM_AW = 10,
    parameter int REG_AW = 4,
    parameter int LAT    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hb_we,
    input  logic [3:0] hb_off,
    input  logic [7:0] hb_wdata,
    output logic [7:0] hb_rdata,
    output logic       ready_o,
    output logic       err_o
);
    localparam int LANES = 4;

    win_t win_d, win_q;
    op_t  new_op, cur_op;
    logic mem_launch, reg_launch, launch;
    logic fin, busy;
    logic mem_we, reg_we;
    logic [31:0] mem_rdata, reg_rdata;

    always_comb begin
        win_d      = win_q;
        mem_launch = hb_we && (hb_off == OFF_MA_LO);
        reg_launch = hb_we && (hb_off == OFF_RDIR);
        if (hb_we) begin
            for (int k = 0; k < LANES; k++) begin
                if (hb_off == (OFF_MD0 + 4'(k))) win_d.mwd[8*k +: 8] = hb_wdata;
                if (hb_off == (OFF_RD0 + 4'(k))) win_d.rwd[8*k +: 8] = hb_wdata;
            end
            case (hb_off)
                OFF_MA_HI:  win_d.madr[23:16] = hb_wdata;
                OFF_MA_MID: win_d.madr[15:8]  = hb_wdata;
                OFF_MA_LO:  win_d.madr[7:0]   = hb_wdata;
                OFF_RA_LO:  win_d.radr[7:0]   = hb_wdata;
                OFF_RA_HI:  win_d.radr[15:8]  = hb_wdata;
                OFF_RDIR:   win_d.rdir        = hb_wdata;
                default: ;
            endcase
        end

        new_op = '0;
        if (reg_launch) begin
            new_op.kind  = OP_REG;
            new_op.is_wr = hb_wdata[0];
            new_op.addr  = {8'h00, win_q.radr};
            new_op.data  = win_q.rwd;
        end else begin
            new_op.kind  = OP_MEM;
            new_op.is_wr = win_q.madr[MEM_WR_BIT];
            new_op.addr  = {2'b00, win_q.madr[21:8], hb_wdata};
            new_op.data  = win_q.mwd;
        end

        if (fin && !cur_op.is_wr) begin
            if (cur_op.kind == OP_MEM) win_d.mrd = mem_rdata;
            else                       win_d.rrd = reg_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    assign launch = mem_launch || reg_launch;

    ibr_txn_seq #(.LAT(LAT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .op_i     (new_op),
        .busy_o   (busy),
        .ready_o  (ready_o),
        .err_o    (err_o),
        .fin_o    (fin),
        .op_o     (cur_op)
    );

    assign mem_we = fin && cur_op.is_wr && (cur_op.kind == OP_MEM);
    assign reg_we = fin && cur_op.is_wr && (cur_op.kind == OP_REG);

    ibr_word_store #(.AW(MEM_AW), .DW(32)) u_mem (
        .clk   (clk),
        .we    (mem_we),
        .waddr (cur_op.addr[MEM_AW-1:0]),
        .wdata (cur_op.data),
        .raddr (cur_op.addr[MEM_AW-1:0]),
        .rdata (mem_rdata)
    );

    ibr_word_store #(.AW(REG_AW), .DW(32)) u_regs (
        .clk   (clk),
        .we    (reg_we),
        .waddr (cur_op.addr[REG_AW-1:0]),
        .wdata (cur_op.data),
        .raddr (cur_op.addr[REG_AW-1:0]),
        .rdata (reg_rdata)
    );

    logic unused_addr_bits;
    assign unused_addr_bits = ^{cur_op.addr, busy};

    always_comb begin
        hb_rdata = 8'h00;
        for (int k = 0; k < LANES; k++) begin
            if (hb_off == (OFF_MD0 + 4'(k))) hb_rdata = win_q.mrd[8*k +: 8];
            if (hb_off == (OFF_RD0 + 4'(k))) hb_rdata = win_q.rrd[8*k +: 8];
        end
        case (hb_off)
            OFF_MA_HI:  hb_rdata = win_q.madr[23:16];
            OFF_MA_MID: hb_rdata = win_q.madr[15:8];
            OFF_MA_LO:  hb_rdata = win_q.madr[7:0];
            OFF_RA_LO:  hb_rdata = win_q.radr[7:0];
            OFF_RA_HI:  hb_rdata = win_q.radr[15:8];
            OFF_RDIR:   hb_rdata = win_q.rdir;
            OFF_STAT:   hb_rdata = {6'b0, ready_o, err_o};
            default: ;
        endcase
    end

    // R7: a staging write alone never moves the captured words
    a_r7_stage_keeps_mem_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_we && (hb_off < 4'd4) && !fin) |=> (win_q.mrd == $past(win_q.mrd)));

    a_r7_stage_keeps_reg_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (hb_we && (hb_off >= OFF_RD0) && (hb_off < OFF_RA_LO) && !fin)
            |=> (win_q.rrd == $past(win_q.rrd)));

    // R2: the memory store is only written at the end of a write access
    a_r2_mem_write_needs_op: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (!ready_o && (cur_op.kind == OP_MEM)));

endmodule

// File: tb/ibr_bridge_test.sv
`timescale 1ns/1ps
module ibr_bridge_test;
    localparam int MEM_AW = 10;
    localparam int REG_AW = 4;
    localparam int LAT    = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hb_we;
    logic [3:0] hb_off;
    logic [7:0] hb_wdata;
    logic [7:0] hb_rdata;
    logic       ready_o;
    logic       err_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [31:0] mdl_mem [1 << MEM_AW];
    logic [31:0] mdl_reg [1 << REG_AW];

    always #4 clk = ~clk;  // 125 MHz

    ibr_bridge #(.MEM_AW(MEM_AW), .REG_AW(REG_AW), .LAT(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .hb_we(hb_we), .hb_off(hb_off),
        .hb_wdata(hb_wdata), .hb_rdata(hb_rdata),
        .ready_o(ready_o), .err_o(err_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [7:0] v);
        @(negedge clk);
        hb_we = 1'b1; hb_off = off; hb_wdata = v;
        @(negedge clk);
        hb_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] off, output logic [7:0] v);
        hb_off = off;
        #1;
        v = hb_rdata;
    endtask

    task automatic wait_ready(input string tag);
        int polls = 0;
        while (!ready_o && polls < 1000) begin
            @(negedge clk);
            polls++;
        end
        chk(ready_o === 1'b1, tag, 32'(ready_o), 32'd1);
    endtask

    task automatic mem_write(input logic [23:0] a, input logic [31:0] d);
        for (int k = 0; k < 4; k++) wr(4'(k), d[8*k +: 8]);
        wr(4'd4, a[23:16] | 8'h40);
        wr(4'd5, a[15:8]);
        wr(4'd6, a[7:0]);
        wait_ready("R2 mem write ready");
        mdl_mem[a[MEM_AW-1:0]] = d;
    endtask

    task automatic mem_read(input logic [23:0] a, output logic [31:0] d);
        logic [7:0] b;
        wr(4'd4, a[23:16] & 8'h3F);
        wr(4'd5, a[15:8]);
        wr(4'd6, a[7:0]);
        wait_ready("R2 mem read ready");
        d = '0;
        for (int k = 3; k >= 0; k--) begin
            wr(4'(k), 8'h00);
            rd(4'(k), b);
            d[8*k +: 8] = b;
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
        for (int k = 0; k < 4; k++) wr(4'(8 + k), d[8*k +: 8]);
        wr(4'd12, a[7:0]);
        wr(4'd13, a[15:8]);
        wr(4'd14, 8'h01);
        wait_ready("R4 reg write ready");
        mdl_reg[a[REG_AW-1:0]] = d;
    endtask

    task automatic reg_read(input logic [15:0] a, output logic [31:0] d);
        logic [7:0] b;
        wr(4'd12, a[7:0]);
        wr(4'd13, a[15:8]);
        wr(4'd14, 8'h00);
        wait_ready("R4 reg read ready");
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), b);
            d[8*k +: 8] = b;
        end
    endtask

    task automatic t_reset;
        logic [7:0] b;
        chk(ready_o === 1'b1, "R5 ready after reset", 32'(ready_o), 32'd1);
        chk(err_o === 1'b0, "R9 err after reset", 32'(err_o), 32'd0);
        rd(4'd15, b);
        chk(b === 8'h02, "R9 status byte after reset", 32'(b), 32'h02);
        rd(4'd0, b);
        chk(b === 8'h00, "R9 mem capture after reset", 32'(b), 32'h00);
        rd(4'd9, b);
        chk(b === 8'h00, "R9 reg capture after reset", 32'(b), 32'h00);
    endtask

    task automatic t_mem_basic;
        logic [31:0] got;
        logic [7:0]  b;
        logic [23:0] addrs [4] = '{24'h000000, 24'h000123, 24'h0003FF, 24'h000200};
        logic [31:0] datas [4] = '{32'hDEADBEEF, 32'h00000001, 32'h80000000, 32'hA5C3_3C5A};
        for (int i = 0; i < 4; i++) mem_write(addrs[i], datas[i]);
        rd(4'd4, b);
        chk(b === 8'h40, "R1 high address byte readback", 32'(b), 32'h40);
        rd(4'd5, b);
        chk(b === 8'h02, "R1 mid address byte readback", 32'(b), 32'h02);
        rd(4'd6, b);
        chk(b === 8'h00, "R1 low address byte readback", 32'(b), 32'h00);
        for (int i = 3; i >= 0; i--) begin
            mem_read(addrs[i], got);
            chk(got === mdl_mem[addrs[i][MEM_AW-1:0]], "R2 mem readback", got,
                mdl_mem[addrs[i][MEM_AW-1:0]]);
        end
    endtask

    task automatic t_latency;
        for (int k = 0; k < 4; k++) wr(4'(k), 8'h11 * 8'(k + 1));
        wr(4'd4, 8'h40);
        wr(4'd5, 8'h00);
        wr(4'd6, 8'h55);
        chk(ready_o === 1'b0, "R5 ready low after launch", 32'(ready_o), 32'd0);
        repeat (LAT - 1) @(negedge clk);
        chk(ready_o === 1'b0, "R6 ready still low one cycle early", 32'(ready_o), 32'd0);
        @(negedge clk);
        chk(ready_o === 1'b1, "R6 ready high after LAT edges", 32'(ready_o), 32'd1);
        mdl_mem[10'h055] = 32'h44332211;
    endtask

    task automatic t_alias;
        logic [31:0] got;
        mem_write(24'h000407, 32'h0BAD_F00D);
        mem_read(24'h000007, got);
        chk(got === 32'h0BADF00D, "R3 mem alias above MEM_AW", got, 32'h0BADF00D);
        mem_read(24'h3F0407, got);
        chk(got === 32'h0BADF00D, "R3 mem alias high byte", got, 32'h0BADF00D);
        mem_read(24'h000055, got);
        chk(got === 32'h44332211, "R2 latency-test word", got, 32'h44332211);
    endtask

    task automatic t_staging;
        logic [31:0] got;
        logic [7:0]  b;
        mem_read(24'h000123, got);
        wr(4'd2, 8'hFF);
        wr(4'd0, 8'h77);
        chk(ready_o === 1'b1, "R7 staging write starts nothing", 32'(ready_o), 32'd1);
        rd(4'd2, b);
        chk(b === got[23:16], "R7 capture lane 2 kept", 32'(b), 32'(got[23:16]));
        rd(4'd0, b);
        chk(b === got[7:0], "R7 capture lane 0 kept", 32'(b), 32'(got[7:0]));
    endtask

    task automatic t_regs;
        logic [31:0] got;
        logic [7:0]  b;
        reg_write(16'h0003, 32'hCAFE_0003);
        reg_write(16'h000C, 32'h1234_5678);
        reg_read(16'h0003, got);
        chk(got === 32'hCAFE0003, "R4 reg readback", got, 32'hCAFE0003);
        reg_read(16'h0013, got);
        chk(got === 32'hCAFE0003, "R3 reg alias above REG_AW", got, 32'hCAFE0003);
        reg_read(16'hAB0C, got);
        chk(got === 32'h12345678, "R3 reg alias high byte", got, 32'h12345678);
        wr(4'd9, 8'h00);
        chk(ready_o === 1'b1, "R7 reg staging write starts nothing", 32'(ready_o), 32'd1);
        rd(4'd9, b);
        chk(b === 8'h56, "R7 reg capture lane 1 kept", 32'(b), 32'h56);
        rd(4'd14, b);
        chk(b === 8'h00, "R4 direction byte readback", 32'(b), 32'h00);
    endtask

    task automatic t_busy;
        logic [31:0] got;
        logic [7:0]  b;
        mem_write(24'h000031, 32'h31313131);
        mem_write(24'h000032, 32'h32323232);
        chk(err_o === 1'b0, "R8 no error before overlap", 32'(err_o), 32'd0);
        for (int k = 0; k < 4; k++) wr(4'(k), 8'hE0 + 8'(k));
        wr(4'd4, 8'h40);
        wr(4'd5, 8'h00);
        wr(4'd6, 8'h31);
        wr(4'd6, 8'h32);  // arrives while busy
        wait_ready("R8 first access completes");
        chk(err_o === 1'b1, "R8 error flag set", 32'(err_o), 32'd1);
        rd(4'd15, b);
        chk(b === 8'h03, "R9 status with error", 32'(b), 32'h03);
        mem_read(24'h000031, got);
        chk(got === 32'hE3E2E1E0, "R8 first access performed", got, 32'hE3E2E1E0);
        mem_read(24'h000032, got);
        chk(got === 32'h32323232, "R8 dropped launch left memory", got, 32'h32323232);
        chk(err_o === 1'b1, "R8 error stays set", 32'(err_o), 32'd1);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; hb_we = 1'b0; hb_off = 4'd0; hb_wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_mem_basic;
        t_latency;
        t_alias;
        t_staging;
        t_regs;
        t_busy;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule